// File: doc/BRIEF.md
# Parallel Port Enhanced-Mode Write Engine

This block runs the host side of one Enhanced Parallel Port write transfer, for either an address byte or a data byte. A system-side write request supplies a register select and a byte; the block pulls its ready output low to stall the host, then runs a four-phase handshake with the peripheral through the wait input and the address or data strobe. It releases the host when the peripheral signals that hold time is met.

A watchdog bounds the part of the handshake that depends on the peripheral. If the peripheral never finishes setup within a set number of clock cycles, the block abandons the transfer, frees the host and raises a sticky timeout flag. Two control inputs change how the bus is driven. A direction bit left at 1 turns the requested write into a read-style bus cycle, and no error is raised. A strobe override forces write mode whatever the direction bit says.

Top module: `epp_wr_ctrl`

## Requirements
- R1: `host_rdy` goes low on the clock edge after `host_wr` is sampled high in idle, and it stays low while either strobe is low and until the cycle completes or aborts.
- R2: After a start, while the synchronized `p_wait_n` is still high, both strobes and `p_write_n` stay high.
- R3: Once `p_wait_n` is low, the block drives the latched byte on `pd_out`, sets `pd_dir` to 0 and drives `p_write_n` low. One cycle later it pulls `p_astb_n` low when `host_sel`=1, or `p_dstb_n` low when `host_sel`=0.
- R4: While a strobe is low, a high level on `p_wait_n` makes the block deassert that strobe. `host_rdy` stays low.
- R5: After the strobe is removed, a low level on `p_wait_n` sets `host_rdy` to 1, with both strobes high.
- R6: If `TMO_CYC` clock cycles pass after a start without `p_wait_n` having been seen high during the strobe phase, the cycle aborts. This applies in the hold-off phase too. On abort `timeout` becomes 1, `host_rdy` becomes 1 and both strobes go high.
- R7: When `ctl_dir`=1 and `ctl_strobe`=0 at the start, the handshake runs unchanged, but `p_write_n` stays high and `pd_dir` stays 1. `timeout` is not set.
- R8: When `ctl_strobe`=1 at the start, the cycle is a write (`p_write_n` low, `pd_dir`=0) whatever `ctl_dir` is.
- R9: `timeout` stays set until it is cleared. With `CLR_ON_READ`=0 a pulse on `stat_wr1` clears it and `stat_rd` has no effect. With `CLR_ON_READ`=1 the roles swap.
- R10: `p_wait_n` passes through a two-flop synchronizer. A change on it cannot move a strobe within two clock edges.
- R11: The two strobes are never low together, and `p_write_n` does not change while a strobe is low.
- R12: During and after reset: `host_rdy`=1, both strobes high, `p_write_n`=1 and `timeout`=0. In idle, `pd_dir` equals `ctl_dir & ~ctl_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write request, sampled in idle |
| host_sel | input | 1 | 1 = address register, 0 = data register |
| host_data | input | 8 | Byte to transfer |
| host_rdy | output | 1 | Low stalls the host |
| ctl_dir | input | 1 | Direction control bit (1 = input) |
| ctl_strobe | input | 1 | Strobe override, forces write mode |
| stat_rd | input | 1 | Status read access pulse |
| stat_wr1 | input | 1 | Write of 1 to the timeout bit |
| timeout | output | 1 | Sticky timeout status bit |
| pd_out | output | 8 | Parallel data bus output value |
| pd_dir | output | 1 | Bus direction, 1 = input |
| p_write_n | output | 1 | Write line, low = write |
| p_astb_n | output | 1 | Address strobe, active low |
| p_dstb_n | output | 1 | Data strobe, active low |
| p_wait_n | input | 1 | Peripheral wait handshake, raw |

## Verification
The bench builds the block with `TMO_CYC`=40 and `CLR_ON_READ`=0. The short limit lets both abort paths (stalled strobe and stalled hold-off) expire within a few dozen cycles, while normal transfers finish well inside the window. With the write-one clear mode, the bench can show that a status read leaves the flag set and a write of one clears it.

// File: rtl/epp_wr_pkg.sv
package epp_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_SETUP = 3'd2,
    ST_STRB  = 3'd3,
    ST_TERM  = 3'd4
  } epp_st_t;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= {STAGES{RST_VAL}};
    else        sr_q <= {sr_q[STAGES-2:0], din};
  end

  assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/epp_wdog.sv
module epp_wdog #(
  parameter int LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == LIM);
  assign cnt_en  = clr | (run & ~expired);

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/epp_status.sv
module epp_status #(
  parameter bit CLR_ON_READ = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic stat_rd,
  input  logic stat_wr1,
  output logic flag
);
  logic clr_req, flag_d, flag_en;

  always_comb begin
    clr_req = CLR_ON_READ ? stat_rd : stat_wr1;
    flag_en = set | clr_req;
    flag_d  = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (flag_en) flag <= flag_d;
  end
endmodule

// File: rtl/epp_wr_fsm.sv
module epp_wr_fsm
  import epp_wr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_sel,
  input  logic [7:0] host_data,
  input  logic       ctl_dir,
  input  logic       ctl_strobe,
  input  logic       wait_s,
  input  logic       wd_expired,
  output logic       wd_clr,
  output logic       wd_run,
  output logic       abort,
  output logic       host_rdy,
  output logic [7:0] pd_out,
  output logic       pd_dir,
  output logic       p_write_n,
  output logic       p_astb_n,
  output logic       p_dstb_n
);
  epp_st_t    st_q, st_d;
  logic       sel_q, wr_mode_q;
  logic [7:0] data_q;
  logic       start, bus_on, in_strb;

  assign start   = (st_q == ST_IDLE) & host_wr;
  assign wd_run  = (st_q == ST_HOLD) | (st_q == ST_SETUP) | (st_q == ST_STRB);
  assign abort   = wd_run & wd_expired;
  assign wd_clr  = start;

  // next-state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (host_wr) st_d = ST_HOLD;
      ST_HOLD:  if (wd_expired) st_d = ST_IDLE;
                else if (!wait_s) st_d = ST_SETUP;
      ST_SETUP: if (wd_expired) st_d = ST_IDLE;
                else st_d = ST_STRB;
      ST_STRB:  if (wd_expired) st_d = ST_IDLE;
                else if (wait_s) st_d = ST_TERM;
      ST_TERM:  if (!wait_s) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // request latch, loaded only when a cycle starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      wr_mode_q <= 1'b0;
      data_q    <= '0;
    end else if (start) begin
      sel_q     <= host_sel;
      wr_mode_q <= ~ctl_dir | ctl_strobe;
      data_q    <= host_data;
    end
  end

  assign bus_on  = (st_q == ST_SETUP) | (st_q == ST_STRB) | (st_q == ST_TERM);
  assign in_strb = (st_q == ST_STRB);

  assign host_rdy  = (st_q == ST_IDLE);
  assign pd_out    = data_q;
  assign pd_dir    = bus_on ? ~wr_mode_q : (ctl_dir & ~ctl_strobe);
  assign p_write_n = ~(bus_on & wr_mode_q);
  assign p_astb_n  = ~(in_strb & sel_q);
  assign p_dstb_n  = ~(in_strb & ~sel_q);
endmodule

// File: rtl/epp_wr_ctrl.sv
module epp_wr_ctrl #(
  parameter int TMO_CYC     = 2000,
  parameter bit CLR_ON_READ = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_sel,
  input  logic [7:0] host_data,
  output logic       host_rdy,
  input  logic       ctl_dir,
  input  logic       ctl_strobe,
  input  logic       stat_rd,
  input  logic       stat_wr1,
  output logic       timeout,
  output logic [7:0] pd_out,
  output logic       pd_dir,
  output logic       p_write_n,
  output logic       p_astb_n,
  output logic       p_dstb_n,
  input  logic       p_wait_n
);
  logic rst_q_n, wait_s, wd_clr, wd_run, wd_exp, abort;

  epp_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .din(1'b1), .dout(rst_q_n)
  );

  epp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wait_sync (
    .clk(clk), .rst_n(rst_q_n), .din(p_wait_n), .dout(wait_s)
  );

  epp_wdog #(.LIMIT(TMO_CYC)) u_wdog (
    .clk(clk), .rst_n(rst_q_n), .clr(wd_clr), .run(wd_run), .expired(wd_exp)
  );

  epp_wr_fsm u_fsm (
    .clk(clk), .rst_n(rst_q_n),
    .host_wr(host_wr), .host_sel(host_sel), .host_data(host_data),
    .ctl_dir(ctl_dir), .ctl_strobe(ctl_strobe),
    .wait_s(wait_s), .wd_expired(wd_exp),
    .wd_clr(wd_clr), .wd_run(wd_run), .abort(abort),
    .host_rdy(host_rdy), .pd_out(pd_out), .pd_dir(pd_dir),
    .p_write_n(p_write_n), .p_astb_n(p_astb_n), .p_dstb_n(p_dstb_n)
  );

  epp_status #(.CLR_ON_READ(CLR_ON_READ)) u_status (
    .clk(clk), .rst_n(rst_q_n), .set(abort),
    .stat_rd(stat_rd), .stat_wr1(stat_wr1), .flag(timeout)
  );
endmodule

// File: rtl/epp_wr_chk.sv
module epp_wr_chk (
  input logic clk,
  input logic rst_n,
  input logic host_rdy,
  input logic p_astb_n,
  input logic p_dstb_n,
  input logic p_write_n,
  input logic wait_s,
  input logic timeout
);
  p_strb_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!p_astb_n && !p_dstb_n));

  p_wr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((!p_astb_n || !p_dstb_n) && ($past(!p_astb_n) || $past(!p_dstb_n)))
      |-> $stable(p_write_n));

  p_rdy_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_astb_n || !p_dstb_n) |-> !host_rdy);

  p_strb_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(p_astb_n) || $fell(p_dstb_n)) |-> !$past(wait_s, 2));

  p_strb_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(p_astb_n) || $rose(p_dstb_n)) |-> ($past(wait_s) || timeout));

  p_rdy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rdy) |-> (p_astb_n && p_dstb_n));

  p_tmo_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> (host_rdy && p_astb_n && p_dstb_n));
endmodule

bind epp_wr_ctrl epp_wr_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .host_rdy(host_rdy),
  .p_astb_n(p_astb_n), .p_dstb_n(p_dstb_n), .p_write_n(p_write_n),
  .wait_s(wait_s), .timeout(timeout)
);

// File: tb/test_epp_wr_ctrl.sv
module test_epp_wr_ctrl;
  logic clk, rst_n;
  logic host_wr, host_sel, host_rdy, ctl_dir, ctl_strobe, stat_rd, stat_wr1;
  logic timeout, pd_dir, p_write_n, p_astb_n, p_dstb_n, p_wait_n;
  logic [7:0] host_data, pd_out;
  int total, bad;
  bit done;

  epp_wr_ctrl #(.TMO_CYC(40), .CLR_ON_READ(1'b0)) i_epp_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_data(host_data), .host_rdy(host_rdy), .ctl_dir(ctl_dir),
    .ctl_strobe(ctl_strobe), .stat_rd(stat_rd), .stat_wr1(stat_wr1),
    .timeout(timeout), .pd_out(pd_out), .pd_dir(pd_dir),
    .p_write_n(p_write_n), .p_astb_n(p_astb_n), .p_dstb_n(p_dstb_n),
    .p_wait_n(p_wait_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {sel, dir, strobe_ovr, data[7:0], exp_write_n, exp_pd_dir}
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1},
    {1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1},
    {1'b0, 1'b1, 1'b1, 8'h81, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_cycle(input logic sel, input logic [7:0] d);
    host_sel = sel; host_data = d; host_wr = 1'b1;
    step(1);
    host_wr = 1'b0;
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; host_wr = 1'b0; host_sel = 1'b0; host_data = '0;
    ctl_dir = 1'b0; ctl_strobe = 1'b0; stat_rd = 1'b0; stat_wr1 = 1'b0;
    p_wait_n = 1'b1;
    step(3);
    check("R12 rdy in reset", 8'(host_rdy), 8'd1);
    check("R12 strobes in reset", 8'({p_astb_n, p_dstb_n}), 8'd3);
    rst_n = 1'b1;
    step(4);
    check("R12 write_n idle", 8'(p_write_n), 8'd1);
    check("R12 timeout idle", 8'(timeout), 8'd0);
    check("R12 pd_dir idle", 8'(pd_dir), 8'd0);

    for (int i = 0; i < 6; i++) begin
      logic [12:0] v;
      v = VEC[i];
      ctl_dir = v[11]; ctl_strobe = v[10]; p_wait_n = 1'b1;
      start_cycle(v[12], v[9:2]);
      check("R1 rdy low at start", 8'(host_rdy), 8'd0);
      step(3);
      check("R2 holdoff strobes", 8'({p_astb_n, p_dstb_n}), 8'd3);
      check("R2 holdoff write_n", 8'(p_write_n), 8'd1);
      p_wait_n = 1'b0;
      step(2);
      check("R10 no early strobe", 8'({p_astb_n, p_dstb_n}), 8'd3);
      step(3);
      check("R3 strobe select", 8'({p_astb_n, p_dstb_n}), v[12] ? 8'd1 : 8'd2);
      check("R3/R7/R8 write_n", 8'(p_write_n), 8'(v[1]));
      check("R3/R7/R8 pd_dir", 8'(pd_dir), 8'(v[0]));
      if (!v[1]) check("R3 data", pd_out, v[9:2]);
      p_wait_n = 1'b1;
      step(5);
      check("R4 strobe removed", 8'({p_astb_n, p_dstb_n}), 8'd3);
      check("R4 rdy still low", 8'(host_rdy), 8'd0);
      p_wait_n = 1'b0;
      step(5);
      check("R5 rdy released", 8'(host_rdy), 8'd1);
      check("R7 no timeout", 8'(timeout), 8'd0);
      p_wait_n = 1'b1;
      step(4);
    end

    // R6: stall in strobe phase
    ctl_dir = 1'b0; ctl_strobe = 1'b0;
    start_cycle(1'b0, 8'h11);
    p_wait_n = 1'b0;
    step(20);
    check("R6 before limit timeout", 8'(timeout), 8'd0);
    check("R6 before limit rdy", 8'(host_rdy), 8'd0);
    check("R6 strobe held", 8'({p_astb_n, p_dstb_n}), 8'd2);
    step(40);
    check("R6 timeout set", 8'(timeout), 8'd1);
    check("R6 rdy released", 8'(host_rdy), 8'd1);
    check("R6 strobes off", 8'({p_astb_n, p_dstb_n}), 8'd3);
    p_wait_n = 1'b1;
    step(4);
    // R9: read does not clear, write-one does
    stat_rd = 1'b1; step(1); stat_rd = 1'b0; step(1);
    check("R9 read keeps flag", 8'(timeout), 8'd1);
    stat_wr1 = 1'b1; step(1); stat_wr1 = 1'b0; step(1);
    check("R9 write one clears", 8'(timeout), 8'd0);

    // R6: stall in hold-off
    start_cycle(1'b1, 8'h22);
    step(60);
    check("R6 holdoff abort", 8'(timeout), 8'd1);
    check("R6 holdoff rdy", 8'(host_rdy), 8'd1);
    check("R6 holdoff write_n", 8'(p_write_n), 8'd1);
    stat_wr1 = 1'b1; step(1); stat_wr1 = 1'b0; step(1);

    // R12: reset in the middle of a cycle
    start_cycle(1'b0, 8'h33);
    p_wait_n = 1'b0;
    step(6);
    check("R12 strobe before reset", 8'(p_dstb_n), 8'd0);
    rst_n = 1'b0;
    step(1);
    check("R12 mid reset strobes", 8'({p_astb_n, p_dstb_n}), 8'd3);
    check("R12 mid reset rdy", 8'(host_rdy), 8'd1);
    p_wait_n = 1'b1;
    rst_n = 1'b1;
    step(4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule